// File: doc/BRIEF.md
# Task-State I/O Permission Checker

This block decides whether a port I/O access of one, two or four bytes may go ahead, using the permission bitmap held in the current task-state segment. A start strobe brings in the task register's base, limit and descriptor attributes, along with the port number and the access width. The block then ends with exactly one verdict: either allow, or a general-protection fault whose error code is zero.

The check first screens the task descriptor, and this step needs no memory access. It then makes up to two 16-bit reads over a request/acknowledge port. The first read fetches the bitmap's starting offset. The second read fetches a two-byte window of the bitmap, so an access whose permission bits cross a byte boundary is judged from one read. Each read address is checked against the segment limit before the read is issued. Deciding whether the check is needed at all, from the privilege level and the I/O privilege field, belongs to the surrounding logic.

Top module: `iopm_checker`

## Requirements
- R1: After reset, `done`, `allow`, `gp_fault` and `rd_req` are all low.
- R2: If the descriptor is not present, or its 4-bit type is not 9, or the limit is below 103, the verdict is a fault. The `done` pulse for it comes in the cycle after the start edge, and no read is requested.
- R3: The first read is requested at the base plus 0x66. `rd_req` and `rd_addr` stay steady until `rd_ack` is seen.
- R4: The byte offset is the fetched 16-bit word plus the port number shifted right by 3, added in 32 bits so it never wraps. If that offset plus 1 is greater than the limit, the verdict is a fault and no second read is made. An offset plus 1 equal to the limit is accepted.
- R5: The second read is at the base plus the byte offset. Read data is little-endian: bits 7:0 come from the lower address.
- R6: The window word is shifted right by the low 3 bits of the port number. The access is allowed only if every one of the low size bits is zero; otherwise the verdict is a fault.
- R7: Each accepted start yields a one-cycle `done` pulse with exactly one of `allow` or `gp_fault` high. `err_code` reads zero on a fault.
- R8: A start that arrives while a check is in progress is ignored. It produces no extra verdict and does not change the check under way.
- R9: `acc_size` gives the width as a byte count (1, 2 or 4), and that count is the number of bitmap bits tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (sampled when idle) |
| tr_base | input | 32 | Task segment base address |
| tr_limit | input | 32 | Task segment limit |
| tr_present | input | 1 | Descriptor present bit |
| tr_type | input | 4 | Descriptor type field |
| port_addr | input | 16 | I/O port number |
| acc_size | input | 3 | Access width in bytes |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 16 | Read data, little-endian |
| done | output | 1 | One-cycle verdict strobe |
| allow | output | 1 | Access permitted (with done) |
| gp_fault | output | 1 | General-protection fault (with done) |
| err_code | output | 16 | Fault error code, always zero |

## Verification
The handshake checks assume that memory raises `rd_ack` for one cycle only, and only while `rd_req` is high, with `rd_data` valid in that same cycle. The bench's memory model acknowledges a request after a programmable delay and then drops `rd_ack` for at least one cycle, so back-to-back reads are seen as distinct transfers. The descriptor inputs, port number and width are held steady while `start` is high and are changed only between checks. The one exception is the busy scenario, which deliberately pulses a second start with different attributes.

// File: rtl/iopm_pkg.sv
package iopm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_MAP  = 2'd2
    } iopm_state_e;

    localparam logic [3:0] TSS_TYPE_AVAIL32 = 4'd9;
    localparam int unsigned TSS_MIN_LIMIT   = 103;
    localparam int unsigned MAP_PTR_OFFSET  = 'h66;
    localparam int unsigned PORT_BYTE_SHIFT = 3;

endpackage

// File: rtl/iopm_desc_screen.sv
module iopm_desc_screen
    import iopm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              present,
    input  logic [3:0]        seg_type,
    input  logic [ADDR_W-1:0] seg_limit,
    output logic              desc_ok
);

    logic type_ok;
    logic limit_ok;

    assign type_ok  = (seg_type == TSS_TYPE_AVAIL32);
    assign limit_ok = (seg_limit >= ADDR_W'(TSS_MIN_LIMIT));
    assign desc_ok  = present && type_ok && limit_ok;

endmodule

// File: rtl/iopm_limit_cmp.sv
module iopm_limit_cmp
    import iopm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] map_ptr,
    input  logic [PORT_W-1:0] port,
    input  logic [ADDR_W-1:0] seg_limit,
    output logic [ADDR_W-1:0] byte_off,
    output logic              fits
);

    localparam int EXT_W = ADDR_W + 1;

    logic [PORT_W-1:0] port_byte;
    logic [EXT_W-1:0]  last_byte;

    assign port_byte = port >> PORT_BYTE_SHIFT;
    assign byte_off  = ADDR_W'(map_ptr) + ADDR_W'(port_byte);
    // two bytes are always read, so the second byte must be within limit
    assign last_byte = {1'b0, byte_off} + EXT_W'(1);
    assign fits      = (last_byte <= {1'b0, seg_limit});

endmodule

// File: rtl/iopm_window_test.sv
module iopm_window_test #(
    parameter int WORD_W = 16,
    parameter int SIZE_W = 3
) (
    input  logic [WORD_W-1:0] window,
    input  logic [2:0]        bit_sel,
    input  logic [SIZE_W-1:0] size_bits,
    output logic              clear
);

    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] mask;

    assign shifted = window >> bit_sel;

    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_mask
            assign mask[i] = (32'(i) < 32'(size_bits));
        end
    endgenerate

    assign clear = ((shifted & mask) == '0);

endmodule

// File: rtl/iopm_checker.sv
module iopm_checker
    import iopm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    parameter int WORD_W = 16,
    parameter int SIZE_W = 3,
    parameter int ERR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] tr_base,
    input  logic [ADDR_W-1:0] tr_limit,
    input  logic              tr_present,
    input  logic [3:0]        tr_type,
    input  logic [PORT_W-1:0] port_addr,
    input  logic [SIZE_W-1:0] acc_size,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done,
    output logic              allow,
    output logic              gp_fault,
    output logic [ERR_W-1:0]  err_code
);

    typedef struct packed {
        iopm_state_e       state;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [PORT_W-1:0] port;
        logic [SIZE_W-1:0] size;
        logic              rd_req;
        logic [ADDR_W-1:0] rd_addr;
        logic              done;
        logic              allow;
        logic              fault;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              desc_ok;
    logic [ADDR_W-1:0] byte_off;
    logic              off_fits;
    logic              bits_clear;

    iopm_desc_screen #(.ADDR_W(ADDR_W)) u_screen (
        .present   (tr_present),
        .seg_type  (tr_type),
        .seg_limit (tr_limit),
        .desc_ok   (desc_ok)
    );

    iopm_limit_cmp #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .WORD_W(WORD_W)) u_limit (
        .map_ptr   (rd_data),
        .port      (ctx_q.port),
        .seg_limit (ctx_q.limit),
        .byte_off  (byte_off),
        .fits      (off_fits)
    );

    iopm_window_test #(.WORD_W(WORD_W), .SIZE_W(SIZE_W)) u_window (
        .window    (rd_data),
        .bit_sel   (ctx_q.port[2:0]),
        .size_bits (ctx_q.size),
        .clear     (bits_clear)
    );

    always_comb begin
        ctx_d       = ctx_q;
        ctx_d.done  = 1'b0;
        ctx_d.allow = 1'b0;
        ctx_d.fault = 1'b0;
        unique case (ctx_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.base  = tr_base;
                    ctx_d.limit = tr_limit;
                    ctx_d.port  = port_addr;
                    ctx_d.size  = acc_size;
                    if (!desc_ok) begin
                        ctx_d.done  = 1'b1;
                        ctx_d.fault = 1'b1;
                    end else begin
                        ctx_d.state   = ST_BASE;
                        ctx_d.rd_req  = 1'b1;
                        ctx_d.rd_addr = tr_base + ADDR_W'(MAP_PTR_OFFSET);
                    end
                end
            end
            ST_BASE: begin
                if (rd_ack) begin
                    if (!off_fits) begin
                        ctx_d.state  = ST_IDLE;
                        ctx_d.rd_req = 1'b0;
                        ctx_d.done   = 1'b1;
                        ctx_d.fault  = 1'b1;
                    end else begin
                        ctx_d.state   = ST_MAP;
                        ctx_d.rd_addr = ctx_q.base + byte_off;
                    end
                end
            end
            ST_MAP: begin
                if (rd_ack) begin
                    ctx_d.state  = ST_IDLE;
                    ctx_d.rd_req = 1'b0;
                    ctx_d.done   = 1'b1;
                    ctx_d.allow  = bits_clear;
                    ctx_d.fault  = !bits_clear;
                end
            end
            default: begin
                ctx_d.state  = ST_IDLE;
                ctx_d.rd_req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign rd_req   = ctx_q.rd_req;
    assign rd_addr  = ctx_q.rd_addr;
    assign done     = ctx_q.done;
    assign allow    = ctx_q.allow;
    assign gp_fault = ctx_q.fault;
    assign err_code = '0;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (allow ^ gp_fault)); // R7
    AST_QUIET_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(allow || gp_fault)); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R3
    AST_BAD_DESC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.state == ST_IDLE && start && !desc_ok) |=> (done && gp_fault && !rd_req)); // R2
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> (rd_addr == ctx_q.base + ADDR_W'(MAP_PTR_OFFSET))); // R3
    AST_MAP_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.state == ST_MAP) |->
            (({1'b0, rd_addr - ctx_q.base} + (ADDR_W+1)'(1)) <= {1'b0, ctx_q.limit})); // R4
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.state != ST_IDLE && start) |=> ($stable(ctx_q.port) && $stable(ctx_q.base))); // R8

endmodule

// File: tb/iopm_checker_bench.sv
module iopm_checker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tr_base = '0;
    logic [31:0] tr_limit = '0;
    logic        tr_present = 1'b0;
    logic [3:0]  tr_type = '0;
    logic [15:0] port_addr = '0;
    logic [2:0]  acc_size = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack;
    logic [15:0] rd_data;
    logic        done, allow, gp_fault;
    logic [15:0] err_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    iopm_checker u_iopm_checker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tr_base(tr_base), .tr_limit(tr_limit),
        .tr_present(tr_present), .tr_type(tr_type),
        .port_addr(port_addr), .acc_size(acc_size),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .allow(allow), .gp_fault(gp_fault),
        .err_code(err_code)
    );

    // byte-addressed memory model, little-endian words
    logic [7:0]  mem [0:4095];
    int          mem_lat = 0;
    int          wait_cnt;
    int          reads;
    int          dones;
    logic [31:0] log_prev, log_last;

    function automatic logic [15:0] word_at(logic [31:0] a);
        return {mem[(a + 1) & 32'hfff], mem[a & 32'hfff]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack   <= 1'b0;
            rd_data  <= '0;
            wait_cnt <= 0;
            reads    <= 0;
            dones    <= 0;
        end else begin
            if (done) dones <= dones + 1;
            if (rd_req && !rd_ack) begin
                if (wait_cnt >= mem_lat) begin
                    rd_ack   <= 1'b1;
                    rd_data  <= word_at(rd_addr);
                    wait_cnt <= 0;
                    reads    <= reads + 1;
                    log_prev <= log_last;
                    log_last <= rd_addr;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end else begin
                rd_ack <= 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_map_ptr(input logic [31:0] base, input logic [15:0] ptr);
        mem[(base + 32'h66) & 32'hfff] = ptr[7:0];
        mem[(base + 32'h67) & 32'hfff] = ptr[15:8];
    endtask

    // runs one check and verifies verdict, error code, read count, pulse width
    task automatic run_access(input logic [31:0] base, input logic [31:0] limit,
                              input bit pres, input logic [3:0] typ,
                              input logic [15:0] port, input logic [2:0] size,
                              input bit exp_allow, input int exp_reads,
                              input string tag, output int latency);
        int r0;
        int n;
        @(negedge clk);
        tr_base = base; tr_limit = limit; tr_present = pres; tr_type = typ;
        port_addr = port; acc_size = size; start = 1'b1;
        r0 = reads;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        latency = n;
        check(done == 1'b1, {tag, " done"}, done, 1);
        check(allow == exp_allow, {tag, " allow"}, allow, exp_allow);
        check(gp_fault == !exp_allow, {tag, " fault"}, gp_fault, !exp_allow);
        if (!exp_allow) check(err_code == 16'h0, {tag, " R7 err_code"}, err_code, 0);
        check((reads - r0) == exp_reads, {tag, " read count"}, reads - r0, exp_reads);
        @(negedge clk);
        check(done == 1'b0 && allow == 1'b0 && gp_fault == 1'b0,
              {tag, " R7 single pulse"}, {done, allow, gp_fault}, 0);
    endtask

    task automatic t_reset();
        check(!done && !allow && !gp_fault && !rd_req, "R1 reset outputs",
              {done, allow, gp_fault, rd_req}, 0);
    endtask

    task automatic t_bad_desc();
        int lat;
        run_access(32'h200, 32'h2000, 1'b0, 4'd9, 16'h20, 3'd1, 1'b0, 0, "R2 not present", lat);
        check(lat == 1, "R2 latency not present", lat, 1);
        run_access(32'h200, 32'h2000, 1'b1, 4'd11, 16'h20, 3'd1, 1'b0, 0, "R2 type 11", lat);
        check(lat == 1, "R2 latency type", lat, 1);
        run_access(32'h200, 32'd102, 1'b1, 4'd9, 16'h0, 3'd1, 1'b0, 0, "R2 limit 102", lat);
        // limit 103 passes the screen; offset 0x68 + 1 > 103 then faults after one read
        run_access(32'h200, 32'd103, 1'b1, 4'd9, 16'h0, 3'd1, 1'b0, 1, "R2 limit 103 screen pass", lat);
    endtask

    task automatic t_basic();
        int lat;
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h20, 3'd1, 1'b1, 2, "R6 clear bit allow", lat);
        check(log_prev == 32'h266, "R3 first read address", log_prev, 32'h266);
        check(log_last == 32'h26c, "R5 second read address", log_last, 32'h26c);
        mem[12'h26c] = 8'h01;
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h20, 3'd1, 1'b0, 2, "R6 set bit fault", lat);
        mem[12'h26c] = 8'h02;
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h20, 3'd1, 1'b1, 2, "R6 neighbour bit allow", lat);
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h21, 3'd1, 1'b0, 2, "R6 bit select 1 fault", lat);
        mem[12'h26c] = 8'h00;
    endtask

    task automatic t_span();
        int lat;
        mem_lat = 2;
        mem[12'h270] = 8'h02; // port 0x41: high byte of the window
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h3e, 3'd4, 1'b0, 2, "R5 span fault little-endian", lat);
        mem[12'h270] = 8'h04; // port 0x42: just outside the four bits
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h3e, 3'd4, 1'b1, 2, "R6 span allow", lat);
        mem[12'h270] = 8'h00;
        mem_lat = 0;
    endtask

    task automatic t_size();
        int lat;
        mem[12'h272] = 8'h02; // port 0x51 denied
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h50, 3'd1, 1'b1, 2, "R9 size 1 allow", lat);
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h50, 3'd2, 1'b0, 2, "R9 size 2 fault", lat);
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h4e, 3'd4, 1'b0, 2, "R9 size 4 fault", lat);
        run_access(32'h200, 32'h2000, 1'b1, 4'd9, 16'h4e, 3'd2, 1'b1, 2, "R9 size 2 below allow", lat);
        mem[12'h272] = 8'h00;
    endtask

    task automatic t_limit();
        int lat;
        // byte offset 0x68 + (0x80 >> 3) = 0x78
        run_access(32'h200, 32'h79, 1'b1, 4'd9, 16'h80, 3'd1, 1'b1, 2, "R4 offset+1 equals limit", lat);
        run_access(32'h200, 32'h78, 1'b1, 4'd9, 16'h80, 3'd1, 1'b0, 1, "R4 offset+1 over limit", lat);
        // 0xffff + 0x1fff = 0x11ffe, must not wrap below limit 0xffff
        set_map_ptr(32'h300, 16'hffff);
        run_access(32'h300, 32'hffff, 1'b1, 4'd9, 16'hffff, 3'd1, 1'b0, 1, "R4 no 16-bit wrap", lat);
    endtask

    task automatic t_busy();
        int d0;
        int n;
        mem_lat = 3;
        @(negedge clk);
        tr_base = 32'h200; tr_limit = 32'h2000; tr_present = 1'b1; tr_type = 4'd9;
        port_addr = 16'h20; acc_size = 3'd1; start = 1'b1;
        d0 = dones;
        @(negedge clk);
        tr_present = 1'b0; port_addr = 16'h21; // second start while busy
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(allow == 1'b1, "R8 busy start ignored verdict", allow, 1);
        repeat (12) @(negedge clk);
        check((dones - d0) == 1, "R8 single verdict", dones - d0, 1);
        mem_lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        set_map_ptr(32'h200, 16'h0068);
        log_prev = '0;
        log_last = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_bad_desc();
        t_basic();
        t_span();
        t_size();
        t_limit();
        t_busy();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule